// File: doc/BRIEF.md
# Dual-Processor SRAM Bank Ownership Arbiter

This block decides which of two processors, a base processor and a stack processor, may use each shared SRAM bank. Each processor reaches the block through its own small register port. The block holds the ownership flags, the request flags, a priority setting and a sharing-mode bit for every bank. It raises an interrupt to a processor when a bank is granted to it, or when the other side wants a bank it holds. Each interrupt cause is kept in a per-processor log. The block also checks every SRAM access made by the base processor against the current ownership and logs the accesses that are not allowed.

There are two sharing schemes. In spinlock mode each side requests a bank for itself, and the hardware grants the bank once it is free. In handshake mode bank 0 governs every bank. Its request bits become cross-processor signals. The stack side raises the base request to say that data is ready, and the base side raises the stack request to say that processing may start. Either signal passes ownership to the side that receives it once the bank is free.

Top module: `sram_bank_owner_arb`

## Requirements
- R1: After reset every register reads 0: handshake mode, equal priority, no owner, no request and empty logs. Both interrupt outputs are low.
- R2: Offset 0 bit 0 is the mode (1 = spinlock, 0 = handshake). Offset 1 bits [1:0] are the priority. Only base-side writes change either register; stack-side writes to them are ignored.
- R3: In spinlock mode, a request on a free bank is granted on the clock edge after the request becomes visible. The requester's ownership bit is set, its request bit is cleared and its grant log bit is set.
- R4: The ownership register at offset 5 holds bit 2b for a base owner and bit 2b+1 for a stack owner of bank b. A write of 1 clears a bit only when the owning side writes it. Writes of 0, and writes by the other side, have no effect.
- R5: When both sides request the same free bank in the same cycle, priority 01 gives the bank to stack and 10 gives it to base. Under 00 or 11 the side that did not receive the previous grant of that bank wins, and base wins first after reset.
- R6: A request pending on a bank owned by the other side sets the owner's relinquish log bit for that bank once. The flag does not set again until the bank has been free. After the owner releases the bank, the request is granted.
- R7: In handshake mode bank 0 alone is arbitrated. The stack side sets the base request (offset 2) and the base side sets the stack request (offset 3). Only bit 0 of a request write is honoured, and writes from the requester itself are ignored. The base access check then uses bank 0 ownership for every bank.
- R8: A base SRAM access to a bank that the base side does not own sets base log bit 0 on the next edge.
- R9: Offset 4 holds the accessing side's own log. Base log: bit 0 invalid access, bit 1+b grant of bank b, bit 1+N+b relinquish of bank b. Stack log: bit b grant, bit N+b relinquish. Each side clears only its own log, bit by bit, by writing 1. Each interrupt output stays high while its log is non-zero.
- R10: Request bits at offsets 2 (base) and 3 (stack), bit b for bank b, can only be set by writes. A write of 0 leaves them unchanged; only a grant clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Base-side register write strobe |
| base_addr | input | ADDR_W | Base-side register offset (read and write) |
| base_wdata | input | DATA_W | Base-side write data |
| base_rdata | output | DATA_W | Base-side read data for base_addr |
| stk_wr_en | input | 1 | Stack-side register write strobe |
| stk_addr | input | ADDR_W | Stack-side register offset (read and write) |
| stk_wdata | input | DATA_W | Stack-side write data |
| stk_rdata | output | DATA_W | Stack-side read data for stk_addr |
| base_acc_vld | input | 1 | Base processor SRAM access in this cycle |
| base_acc_bank | input | IDX_W | Bank index of that access |
| base_irq | output | 1 | Base interrupt, high while the base log is non-zero |
| stk_irq | output | 1 | Stack interrupt, high while the stack log is non-zero |

## Verification
The assertions assume that `base_acc_bank` names an existing bank. They also assume that the mode is changed only while no bank is owned and no request is pending, because the meaning of pending bits changes with the mode. The stimulus respects both assumptions: it switches mode only after every bank has been released and every log has been cleared, and it makes accesses only to banks 0 and 1. Contention is produced on purpose, with same-cycle writes from both sides. All other traffic comes from one side at a time, so that each expected ownership value follows from a single known event.

// File: rtl/sbo_pkg.sv
package sbo_pkg;

   typedef enum logic [1:0] {
      PRIO_EQUAL = 2'b00,
      PRIO_STACK = 2'b01,
      PRIO_BASE  = 2'b10,
      PRIO_SPARE = 2'b11
   } prio_e;

   localparam int unsigned OFS_MODE     = 0;
   localparam int unsigned OFS_PRIO     = 1;
   localparam int unsigned OFS_REQ_BASE = 2;
   localparam int unsigned OFS_REQ_STK  = 3;
   localparam int unsigned OFS_LOG      = 4;
   localparam int unsigned OFS_OWN      = 5;

endpackage

// File: rtl/sbo_bank_arb.sv
// One bank: ownership, requests, tie-break memory and relinquish tracking.
module sbo_bank_arb
   import sbo_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  prio_e prio,
   input  logic  set_req_base,
   input  logic  set_req_stk,
   input  logic  clr_own_base,
   input  logic  clr_own_stk,
   output logic  own_base,
   output logic  own_stk,
   output logic  req_base,
   output logic  req_stk,
   output logic  gnt_base,
   output logic  gnt_stk,
   output logic  rel_to_base,
   output logic  rel_to_stk
);

   logic free;
   logic pick_stk;
   logic last_base_q;
   logic rel_sent_q;

   assign free = !own_base && !own_stk;

   always_comb begin
      case (prio)
         PRIO_STACK: pick_stk = 1'b1;
         PRIO_BASE:  pick_stk = 1'b0;
         default:    pick_stk = last_base_q;
      endcase
   end

   assign gnt_base    = en && free && req_base && (!req_stk || !pick_stk);
   assign gnt_stk     = en && free && req_stk  && (!req_base || pick_stk);
   assign rel_to_base = en && own_base && req_stk  && !rel_sent_q;
   assign rel_to_stk  = en && own_stk  && req_base && !rel_sent_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_base    <= 1'b0;
         own_stk     <= 1'b0;
         req_base    <= 1'b0;
         req_stk     <= 1'b0;
         last_base_q <= 1'b0;
         rel_sent_q  <= 1'b0;
      end else begin
         own_base <= (own_base && !clr_own_base) || gnt_base;
         own_stk  <= (own_stk  && !clr_own_stk)  || gnt_stk;
         req_base <= (req_base && !gnt_base) || set_req_base;
         req_stk  <= (req_stk  && !gnt_stk)  || set_req_stk;
         if (gnt_base)
            last_base_q <= 1'b1;
         else if (gnt_stk)
            last_base_q <= 1'b0;
         rel_sent_q <= free ? 1'b0 : (rel_sent_q || rel_to_base || rel_to_stk);
      end
   end

endmodule

// File: rtl/sbo_irq_log.sv
// Sticky cause log: hardware sets, software clears by writing 1.
module sbo_irq_log #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] log_q,
   output logic         irq
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         log_q <= '0;
      else
         log_q <= (log_q & ~clr) | set;
   end

   assign irq = |log_q;

endmodule

// File: rtl/sbo_access_chk.sv
// Flags a base-side SRAM access to a bank the base side does not hold.
module sbo_access_chk #(
   parameter int NUM_BANKS = 2,
   parameter int IDX_W     = 1
) (
   input  logic                 acc_vld,
   input  logic [IDX_W-1:0]     acc_bank,
   input  logic                 spin,
   input  logic [NUM_BANKS-1:0] own_base,
   output logic                 invalid
);

   logic held;

   generate
      if ((1 << IDX_W) == NUM_BANKS) begin : g_full_index
         assign held = spin ? own_base[acc_bank] : own_base[0];
      end else begin : g_sparse_index
         logic in_range;
         assign in_range = 32'(acc_bank) < NUM_BANKS;
         always_comb begin
            held = 1'b0;
            for (int b = 0; b < NUM_BANKS; b++)
               if (32'(acc_bank) == b)
                  held = spin ? own_base[b] : own_base[0];
            held = held && in_range;
         end
      end
   endgenerate

   assign invalid = acc_vld && !held;

endmodule

// File: rtl/sram_bank_owner_arb.sv
module sram_bank_owner_arb
   import sbo_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_wr_en,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [DATA_W-1:0] base_wdata,
   output logic [DATA_W-1:0] base_rdata,
   input  logic              stk_wr_en,
   input  logic [ADDR_W-1:0] stk_addr,
   input  logic [DATA_W-1:0] stk_wdata,
   output logic [DATA_W-1:0] stk_rdata,
   input  logic              base_acc_vld,
   input  logic [IDX_W-1:0]  base_acc_bank,
   output logic              base_irq,
   output logic              stk_irq
);

   localparam int BASE_LOG_W = 1 + 2 * NUM_BANKS;
   localparam int STK_LOG_W  = 2 * NUM_BANKS;
   localparam int OWN_W      = 2 * NUM_BANKS;

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_PRIO = ADDR_W'(OFS_PRIO);
   localparam logic [ADDR_W-1:0] A_REQB = ADDR_W'(OFS_REQ_BASE);
   localparam logic [ADDR_W-1:0] A_REQS = ADDR_W'(OFS_REQ_STK);
   localparam logic [ADDR_W-1:0] A_LOG  = ADDR_W'(OFS_LOG);
   localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("NUM_BANKS must be at least 1");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must be at least 3");
      end
      if (DATA_W < BASE_LOG_W || DATA_W < OWN_W || DATA_W < 2) begin : g_bad_data
         $error("DATA_W too narrow for the log and ownership fields");
      end
      if ((1 << IDX_W) < NUM_BANKS) begin : g_bad_idx
         $error("IDX_W cannot address every bank");
      end
   endgenerate

   // ---------------- mode and priority (base side only) ----------------
   logic  spin_q;
   prio_e prio_q;
   logic  base_wr_mode, base_wr_prio;

   assign base_wr_mode = base_wr_en && (base_addr == A_MODE);
   assign base_wr_prio = base_wr_en && (base_addr == A_PRIO);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         spin_q <= 1'b0;
         prio_q <= PRIO_EQUAL;
      end else begin
         if (base_wr_mode) spin_q <= base_wdata[0];
         if (base_wr_prio) prio_q <= prio_e'(base_wdata[1:0]);
      end
   end

   // ---------------- decoded write strobes ----------------
   logic wr_base_reqb, wr_base_reqs, wr_base_own, wr_base_log;
   logic wr_stk_reqb,  wr_stk_reqs,  wr_stk_own,  wr_stk_log;

   assign wr_base_reqb = base_wr_en && (base_addr == A_REQB);
   assign wr_base_reqs = base_wr_en && (base_addr == A_REQS);
   assign wr_base_own  = base_wr_en && (base_addr == A_OWN);
   assign wr_base_log  = base_wr_en && (base_addr == A_LOG);
   assign wr_stk_reqb  = stk_wr_en  && (stk_addr  == A_REQB);
   assign wr_stk_reqs  = stk_wr_en  && (stk_addr  == A_REQS);
   assign wr_stk_own   = stk_wr_en  && (stk_addr  == A_OWN);
   assign wr_stk_log   = stk_wr_en  && (stk_addr  == A_LOG);

   // ---------------- per-bank slices ----------------
   logic [NUM_BANKS-1:0] own_base_v, own_stk_v, req_base_v, req_stk_v;
   logic [NUM_BANKS-1:0] gnt_base_v, gnt_stk_v, rel_base_v, rel_stk_v;
   logic [OWN_W-1:0]     own_pack;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic set_rb, set_rs, bank_en;
         if (b == 0) begin : g_lead
            // Lead bank: requester swaps sides when handshake mode is active.
            assign bank_en = 1'b1;
            assign set_rb  = spin_q ? (wr_base_reqb && base_wdata[b])
                                    : (wr_stk_reqb  && stk_wdata[0]);
            assign set_rs  = spin_q ? (wr_stk_reqs  && stk_wdata[b])
                                    : (wr_base_reqs && base_wdata[0]);
         end else begin : g_follow
            // Follower banks are only arbitrated in spinlock mode.
            assign bank_en = spin_q;
            assign set_rb  = spin_q && wr_base_reqb && base_wdata[b];
            assign set_rs  = spin_q && wr_stk_reqs  && stk_wdata[b];
         end

         sbo_bank_arb u_arb (
            .clk          (clk),
            .rst_n        (rst_n),
            .en           (bank_en),
            .prio         (prio_q),
            .set_req_base (set_rb),
            .set_req_stk  (set_rs),
            .clr_own_base (wr_base_own && base_wdata[2*b]),
            .clr_own_stk  (wr_stk_own  && stk_wdata[2*b+1]),
            .own_base     (own_base_v[b]),
            .own_stk      (own_stk_v[b]),
            .req_base     (req_base_v[b]),
            .req_stk      (req_stk_v[b]),
            .gnt_base     (gnt_base_v[b]),
            .gnt_stk      (gnt_stk_v[b]),
            .rel_to_base  (rel_base_v[b]),
            .rel_to_stk   (rel_stk_v[b])
         );

         assign own_pack[2*b]   = own_base_v[b];
         assign own_pack[2*b+1] = own_stk_v[b];
      end
   endgenerate

   // ---------------- access check ----------------
   logic base_invalid;

   sbo_access_chk #(
      .NUM_BANKS (NUM_BANKS),
      .IDX_W     (IDX_W)
   ) u_acc (
      .acc_vld  (base_acc_vld),
      .acc_bank (base_acc_bank),
      .spin     (spin_q),
      .own_base (own_base_v),
      .invalid  (base_invalid)
   );

   // ---------------- interrupt logs ----------------
   logic [BASE_LOG_W-1:0] base_log;
   logic [STK_LOG_W-1:0]  stk_log;

   sbo_irq_log #(.W(BASE_LOG_W)) u_base_log (
      .clk   (clk),
      .rst_n (rst_n),
      .set   ({rel_base_v, gnt_base_v, base_invalid}),
      .clr   (wr_base_log ? base_wdata[BASE_LOG_W-1:0] : '0),
      .log_q (base_log),
      .irq   (base_irq)
   );

   sbo_irq_log #(.W(STK_LOG_W)) u_stk_log (
      .clk   (clk),
      .rst_n (rst_n),
      .set   ({rel_stk_v, gnt_stk_v}),
      .clr   (wr_stk_log ? stk_wdata[STK_LOG_W-1:0] : '0),
      .log_q (stk_log),
      .irq   (stk_irq)
   );

   // ---------------- read ports ----------------
   always_comb begin
      base_rdata = '0;
      case (base_addr)
         A_MODE:  base_rdata = DATA_W'(spin_q);
         A_PRIO:  base_rdata = DATA_W'(prio_q);
         A_REQB:  base_rdata = DATA_W'(req_base_v);
         A_REQS:  base_rdata = DATA_W'(req_stk_v);
         A_LOG:   base_rdata = DATA_W'(base_log);
         A_OWN:   base_rdata = DATA_W'(own_pack);
         default: base_rdata = '0;
      endcase
   end

   always_comb begin
      stk_rdata = '0;
      case (stk_addr)
         A_MODE:  stk_rdata = DATA_W'(spin_q);
         A_PRIO:  stk_rdata = DATA_W'(prio_q);
         A_REQB:  stk_rdata = DATA_W'(req_base_v);
         A_REQS:  stk_rdata = DATA_W'(req_stk_v);
         A_LOG:   stk_rdata = DATA_W'(stk_log);
         A_OWN:   stk_rdata = DATA_W'(own_pack);
         default: stk_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sbo_checker.sv
module sbo_checker
   import sbo_pkg::*;
#(
   parameter int NUM_BANKS = 2,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 base_wr_en,
   input logic [ADDR_W-1:0]    base_addr,
   input logic [DATA_W-1:0]    base_wdata,
   input logic                 stk_wr_en,
   input logic [ADDR_W-1:0]    stk_addr,
   input logic [DATA_W-1:0]    stk_wdata,
   input logic                 base_acc_vld,
   input logic [IDX_W-1:0]     base_acc_bank,
   input logic                 base_irq,
   input logic                 stk_irq,
   input logic                 spin,
   input logic [NUM_BANKS-1:0] own_base,
   input logic [NUM_BANKS-1:0] own_stk,
   input logic [NUM_BANKS-1:0] req_base,
   input logic [NUM_BANKS-1:0] req_stk,
   input logic [2*NUM_BANKS:0] base_log
);

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_LOG  = ADDR_W'(OFS_LOG);
   localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFS_OWN);

   logic acc_held;
   always_comb begin
      acc_held = 1'b0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (32'(base_acc_bank) == b)
            acc_held = spin ? own_base[b] : own_base[0];
   end

   AST_MODE_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(spin) |-> $past(base_wr_en && base_addr == A_MODE)); // R2

   AST_INVALID_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (base_acc_vld && !acc_held) |=> base_log[0]); // R8

   AST_BASE_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(base_irq) |-> $past(base_wr_en && base_addr == A_LOG)); // R9

   AST_STK_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stk_irq) |-> $past(stk_wr_en && stk_addr == A_LOG)); // R9

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         AST_OWN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(own_base[b] && own_stk[b])); // R3

         AST_BASE_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(own_base[b]) |-> ($past(req_base[b]) && $past(!own_stk[b]))); // R3

         AST_STK_GRANT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(own_stk[b]) |-> ($past(req_stk[b]) && $past(!own_base[b]))); // R3

         AST_BASE_OWN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(own_base[b]) |-> $past(base_wr_en && base_addr == A_OWN
                                         && base_wdata[2*b])); // R4

         AST_STK_OWN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(own_stk[b]) |-> $past(stk_wr_en && stk_addr == A_OWN
                                        && stk_wdata[2*b+1])); // R4

         AST_BASE_REQ_HW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(req_base[b]) |-> own_base[b]); // R10

         AST_STK_REQ_HW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(req_stk[b]) |-> own_stk[b]); // R10
      end
   endgenerate

endmodule

bind sram_bank_owner_arb sbo_checker #(
   .NUM_BANKS (NUM_BANKS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .IDX_W     (IDX_W)
) u_sbo_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .base_wr_en    (base_wr_en),
   .base_addr     (base_addr),
   .base_wdata    (base_wdata),
   .stk_wr_en     (stk_wr_en),
   .stk_addr      (stk_addr),
   .stk_wdata     (stk_wdata),
   .base_acc_vld  (base_acc_vld),
   .base_acc_bank (base_acc_bank),
   .base_irq      (base_irq),
   .stk_irq       (stk_irq),
   .spin          (spin_q),
   .own_base      (own_base_v),
   .own_stk       (own_stk_v),
   .req_base      (req_base_v),
   .req_stk       (req_stk_v),
   .base_log      (base_log)
);

// File: tb/tb_sram_bank_owner_arb.sv
`timescale 1ns/1ps
module tb_sram_bank_owner_arb;

   localparam int NB = 2;
   localparam int AW = 3;
   localparam int DW = 32;
   localparam int IW = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          base_wr_en = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [DW-1:0] base_wdata = '0;
   logic [DW-1:0] base_rdata;
   logic          stk_wr_en = 1'b0;
   logic [AW-1:0] stk_addr = '0;
   logic [DW-1:0] stk_wdata = '0;
   logic [DW-1:0] stk_rdata;
   logic          base_acc_vld = 1'b0;
   logic [IW-1:0] base_acc_bank = '0;
   logic          base_irq, stk_irq;

   int n_chk = 0;
   int n_bad = 0;
   int last_base [NB];

   always #2.5 clk = ~clk;

   sram_bank_owner_arb #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut (
      .clk (clk), .rst_n (rst_n),
      .base_wr_en (base_wr_en), .base_addr (base_addr), .base_wdata (base_wdata),
      .base_rdata (base_rdata),
      .stk_wr_en (stk_wr_en), .stk_addr (stk_addr), .stk_wdata (stk_wdata),
      .stk_rdata (stk_rdata),
      .base_acc_vld (base_acc_vld), .base_acc_bank (base_acc_bank),
      .base_irq (base_irq), .stk_irq (stk_irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input bit stk, input int a, input int d);
      @(negedge clk);
      if (stk) begin stk_wr_en = 1'b1; stk_addr = AW'(a); stk_wdata = DW'(d); end
      else     begin base_wr_en = 1'b1; base_addr = AW'(a); base_wdata = DW'(d); end
      @(negedge clk);
      base_wr_en = 1'b0;
      stk_wr_en  = 1'b0;
   endtask

   task automatic wr_both(input int ab, input int db, input int as, input int ds);
      @(negedge clk);
      base_wr_en = 1'b1; base_addr = AW'(ab); base_wdata = DW'(db);
      stk_wr_en  = 1'b1; stk_addr  = AW'(as); stk_wdata  = DW'(ds);
      @(negedge clk);
      base_wr_en = 1'b0;
      stk_wr_en  = 1'b0;
   endtask

   task automatic rd(input bit stk, input int a, output int v);
      if (stk) stk_addr = AW'(a); else base_addr = AW'(a);
      #1;
      v = stk ? int'(stk_rdata) : int'(base_rdata);
   endtask

   task automatic acc(input int bank);
      @(negedge clk);
      base_acc_vld = 1'b1; base_acc_bank = IW'(bank);
      @(negedge clk);
      base_acc_vld = 1'b0;
   endtask

   task automatic clear_logs();
      wr(0, 4, 'h1F);
      wr(1, 4, 'hF);
   endtask

   task automatic run_all();
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick(1);

      // ---- reset state
      for (int a = 0; a < 6; a++) begin
         rd(0, a, v); chk("R1 base read", v, 0);
         rd(1, a, v); chk("R1 stack read", v, 0);
      end
      chk("R1 base_irq", int'(base_irq), 0);
      chk("R1 stk_irq", int'(stk_irq), 0);

      // ---- mode / priority write permission
      wr(1, 0, 1); rd(0, 0, v); chk("R2 stack mode write ignored", v, 0);
      wr(1, 1, 2); rd(0, 1, v); chk("R2 stack prio write ignored", v, 0);
      wr(0, 0, 1); rd(1, 0, v); chk("R2 base mode write", v, 1);

      // ---- spinlock grant of free bank 0 to base
      wr(0, 2, 1); tick(1);
      rd(0, 5, v); chk("R3 owner after grant", v, 'h1);
      rd(0, 2, v); chk("R3 request cleared", v, 0);
      rd(0, 4, v); chk("R9 base grant bit", v, 'h2);
      chk("R9 base_irq high", int'(base_irq), 1);
      rd(1, 4, v); chk("R9 stack log untouched", v, 0);

      // ---- ownership clear rules
      wr(1, 5, 'h1); rd(0, 5, v); chk("R4 stack cannot clear base bit", v, 'h1);
      wr(0, 5, 'h2); rd(0, 5, v); chk("R4 base write to stack bit", v, 'h1);
      wr(0, 5, 'h0); rd(0, 5, v); chk("R4 zero write", v, 'h1);
      wr(1, 4, 'h1F); rd(0, 4, v); chk("R9 stack cannot clear base log", v, 'h2);
      wr(0, 4, 'h2); rd(0, 4, v); chk("R9 base log w1c", v, 0);
      chk("R9 base_irq low", int'(base_irq), 0);

      // ---- relinquish on contended bank
      wr(1, 3, 1); tick(1);
      rd(0, 4, v); chk("R6 relinquish to base", v, 'h8);
      rd(1, 3, v); chk("R6 stack request pending", v, 1);
      wr(1, 3, 0); rd(1, 3, v); chk("R10 zero write keeps request", v, 1);
      wr(0, 4, 'h1F); tick(3);
      rd(0, 4, v); chk("R6 relinquish only once", v, 0);
      wr(0, 5, 'h1); tick(1);
      rd(0, 5, v); chk("R6 granted after release", v, 'h2);
      rd(1, 4, v); chk("R6 stack grant log", v, 'h1);
      rd(1, 3, v); chk("R10 request cleared by grant", v, 0);
      chk("R9 stk_irq high", int'(stk_irq), 1);
      wr(1, 4, 'hF);

      // ---- invalid access
      acc(0); rd(0, 4, v); chk("R8 access to stack-held bank", v, 'h1);
      wr(0, 4, 'h1);
      acc(1); rd(0, 4, v); chk("R8 access to free bank", v, 'h1);
      wr(0, 4, 'h1);
      wr(0, 2, 'h2); tick(1);
      rd(0, 5, v); chk("R3 bank 1 grant", v, 'h6);
      rd(0, 4, v); chk("R9 bank 1 grant bit", v, 'h4);
      acc(1); rd(0, 4, v); chk("R8 held access not flagged", v, 'h4);
      wr(1, 5, 'h2); wr(0, 5, 'h4);
      clear_logs();
      rd(0, 5, v); chk("R4 all released", v, 0);
      last_base[0] = 0;
      last_base[1] = 1;

      // ---- contention sweep over priority codes and banks
      for (int p = 0; p < 4; p++) begin
         wr(0, 1, p);
         rd(1, 1, v); chk("R2 prio readback", v, p);
         for (int rep = 0; rep < 2; rep++) begin
            for (int b = 0; b < NB; b++) begin
               int es;
               es = (p == 1) ? 1 : (p == 2) ? 0 : last_base[b];
               wr_both(2, 1 << b, 3, 1 << b);
               tick(1);
               rd(0, 5, v);
               chk("R5 contention winner", v, (es ? 2 : 1) << (2 * b));
               wr(es != 0, 5, (es ? 2 : 1) << (2 * b));
               tick(1);
               rd(0, 5, v);
               chk("R6 loser granted after release", v, (es ? 1 : 2) << (2 * b));
               wr(es == 0, 5, (es ? 1 : 2) << (2 * b));
               last_base[b] = es;
               clear_logs();
            end
         end
      end

      // ---- handshake mode
      wr(0, 1, 0);
      wr(0, 0, 0); rd(1, 0, v); chk("R7 handshake selected", v, 0);
      wr(1, 2, 3); tick(1);
      rd(0, 5, v); chk("R7 data-ready grants bank 0 to base", v, 'h1);
      rd(0, 2, v); chk("R7 upper request bit ignored", v, 0);
      rd(0, 4, v); chk("R9 handshake grant log", v, 'h2);
      acc(1); rd(0, 4, v); chk("R7 bank 0 governs bank 1 access", v, 'h2);
      wr(0, 3, 2); tick(1);
      rd(0, 3, v); chk("R7 stack request bit 1 ignored", v, 0);
      wr(0, 5, 1);
      wr(0, 2, 1); tick(1);
      rd(0, 2, v); chk("R7 base self-request ignored", v, 0);
      rd(0, 5, v); chk("R7 no owner after self-request", v, 0);
      wr(0, 3, 1); tick(1);
      rd(0, 5, v); chk("R7 start grants bank 0 to stack", v, 'h2);
      rd(1, 4, v); chk("R7 stack grant log", v, 'h1);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule